// File: doc/BRIEF.md
# Flash Read Window Bridge

This block gives a host a read-only view of the upper part of a serial flash device. The host addresses a window whose length is a power of two. Window offset zero falls on the first byte of the last window-sized region of the flash, so the final byte of the window is the final byte of the device. Each host request names an offset. The block ignores the three low offset bits and fetches the eight-byte unit that contains that offset. It returns the unit as one 64-bit word.

For each request the block drives one plain single-bit serial read. The chip select goes low, an opcode is sent, then an address of three or four bytes, and then eight data bytes are clocked in with no dummy cycles. Two configuration inputs are captured when a request is accepted. The first picks the address length. The second is an 8-bit page value that is XOR-ed into address bits 31:24. Only one read is in flight at a time, and the request channel is held not-ready until the response has been delivered.

Top module: `spi_window_reader`

## Requirements
- R1: After reset, req_ready is 1, spi_cs_n is 1, spi_sck is 0 and rsp_valid is 0.
- R2: With a 32-bit address phase and a zero page value, window offset 0 addresses flash byte 2^FLASH_AW − 2^WIN_AW. The last eight-byte unit of the window addresses the last eight bytes of the flash.
- R3: Offset bits 2:0 have no effect. The fetched unit starts at the offset with those bits cleared.
- R4: When cfg_addr32 is 0, opcode 0x03 is sent, followed by address bits 23:0 as three bytes. cfg_page has no effect on any transmitted bit.
- R5: When cfg_addr32 is 1, opcode 0x13 is sent, followed by four address bytes. The first of those bytes is address bits 31:24 XOR cfg_page.
- R6: The serial bus runs in clock mode 0. spi_sck idles low while the select is high. Bits go out most significant first and hold steady across every rising edge. The select stays low for the whole read, and data follows the address with no dummy cycles.
- R7: rsp_data is little-endian: the byte at the lowest flash address sits in bits 7:0, and the byte at address +k sits in bits 8k+7:8k.
- R8: rsp_valid is a one-cycle pulse. It rises 2·(8+8·B)+128 clock edges after the accepting edge, where B is the address byte count. The select is high while rsp_valid is high.
- R9: Only one read is outstanding. req_ready is 0 from the accepting edge until the response, and it returns to 1 on the edge that raises rsp_valid.
- R10: cfg_addr32 and cfg_page are sampled at the accepting edge. Later changes do not affect the read in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Bridge idle, request is accepted |
| req_offset | input | WIN_AW | Byte offset into the window |
| cfg_addr32 | input | 1 | 1 selects a four-byte address phase, 0 a three-byte one |
| cfg_page | input | 8 | Value XOR-ed into address bits 31:24 |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 64 | Eight bytes, lowest address in bits 7:0 |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A response is due 192 clock edges after the accepting edge for a three-byte address, and 208 edges after it for a four-byte address. The driver records the cycle counter at acceptance, together with the expected opcode, wire address and data. The monitor takes one item from the queue on each rsp_valid and compares the elapsed cycles against that count. A flash model on the serial pins captures the opcode and address it actually receives, and it answers from an address-derived pattern, so a wrong translation shows up both in the address check and in the data check. Both the driver and the monitor sample at the falling clock edge, and after every acceptance the driver changes the configuration inputs to test the capture rule.

// File: rtl/spi_window_reader.sv
module spi_window_reader #(
  parameter int FLASH_AW = 25,
  parameter int WIN_AW   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WIN_AW-1:0] req_offset,
  input  logic              cfg_addr32,
  input  logic [7:0]        cfg_page,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam logic [32:0] WIN_BASE = (33'd1 << FLASH_AW) - (33'd1 << WIN_AW);
  localparam int HDR_W = 40;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_RECV} state_t;

  state_t            st_q;
  logic [HDR_W-1:0]  tx_q;
  logic [63:0]       rx_q;
  logic [5:0]        cnt_q;
  logic              ph_q;
  logic              a32_q;

  logic [31:0] flash_addr, paged_addr;
  logic [HDR_W-1:0] hdr;
  logic [63:0] rx_next, rx_swapped;
  logic last_tx;

  assign flash_addr = WIN_BASE[31:0]
                    + {{(32-WIN_AW){1'b0}}, req_offset[WIN_AW-1:3], 3'b000};
  assign paged_addr = flash_addr ^ {cfg_page, 24'h0};
  assign hdr = cfg_addr32 ? {8'h13, paged_addr}
                          : {8'h03, paged_addr[23:0], 8'h00};
  assign last_tx = (cnt_q == (a32_q ? 6'd39 : 6'd31));
  assign rx_next = {rx_q[62:0], spi_miso};

  for (genvar k = 0; k < 8; k++) begin : g_swap
    assign rx_swapped[8*k +: 8] = rx_next[8*(7-k) +: 8];
  end

  assign req_ready = (st_q == S_IDLE);
  assign spi_sck   = ph_q;
  assign spi_mosi  = tx_q[HDR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      tx_q      <= '0;
      rx_q      <= '0;
      cnt_q     <= '0;
      ph_q      <= 1'b0;
      a32_q     <= 1'b0;
      spi_cs_n  <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (req_valid) begin
            tx_q     <= hdr;
            a32_q    <= cfg_addr32;
            cnt_q    <= '0;
            ph_q     <= 1'b0;
            spi_cs_n <= 1'b0;
            st_q     <= S_SEND;
          end
        end
        S_SEND: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            tx_q  <= {tx_q[HDR_W-2:0], 1'b0};
            cnt_q <= cnt_q + 6'd1;
            if (last_tx) begin
              cnt_q <= '0;
              st_q  <= S_RECV;
            end
          end
        end
        S_RECV: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            rx_q  <= rx_next;
            cnt_q <= cnt_q + 6'd1;
            if (cnt_q == 6'd63) begin
              rsp_valid <= 1'b1;
              rsp_data  <= rx_swapped;
              spi_cs_n  <= 1'b1;
              st_q      <= S_IDLE;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

module spi_window_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi
);
  AST_RSP_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R8
  AST_RSP_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> spi_cs_n); // R8
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> spi_cs_n); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                     (req_valid && req_ready) |=> (!req_ready && !spi_cs_n)); // R9
  AST_CS_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(spi_cs_n) |-> rsp_valid); // R9
  AST_SCK_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sck); // R6
  AST_MOSI_SETUP:  assert property (@(posedge clk) disable iff (!rst_n) $rose(spi_sck) |-> $stable(spi_mosi)); // R6
endmodule

bind spi_window_reader spi_window_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/spi_window_reader_tb.sv
`timescale 1ns/1ps
module spi_window_reader_tb;
  localparam int FLASH_AW = 25;
  localparam int WIN_AW   = 24;
  localparam logic [31:0] BASE = 32'h0100_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [WIN_AW-1:0] req_offset = '0;
  logic cfg_addr32 = 1'b0;
  logic [7:0] cfg_page = 8'h00;
  logic rsp_valid;
  logic [63:0] rsp_data;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  logic [7:0]  q_op[$];
  logic [31:0] q_addr[$];
  logic [63:0] q_data[$];
  int          q_t0[$];
  int          q_lat[$];
  string       q_tag[$];

  logic [7:0]  got_op;
  logic [31:0] got_addr;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_window_reader #(.FLASH_AW(FLASH_AW), .WIN_AW(WIN_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .cfg_addr32(cfg_addr32), .cfg_page(cfg_page),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd29;
    return m ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  function automatic logic [63:0] funit(input logic [31:0] a);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[8*k +: 8] = fbyte(a + k);
    return d;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flash model: mode 0, samples on rising, drives on falling
  initial begin
    logic [39:0] cap;
    int bcnt, hb;
    forever begin
      @(negedge spi_cs_n);
      bcnt = 0; cap = '0; hb = 32;
      forever begin
        @(posedge spi_sck or posedge spi_cs_n);
        if (spi_cs_n) break;
        if (bcnt < 40) cap = {cap[38:0], spi_mosi};
        bcnt++;
        if (bcnt == 8) begin
          got_op = cap[7:0];
          hb = (cap[7:0] == 8'h13) ? 40 : 32;
        end
        if (bcnt == hb) got_addr = (hb == 40) ? cap[31:0] : {8'h00, cap[23:0]};
        @(negedge spi_sck or posedge spi_cs_n);
        if (spi_cs_n) break;
        if (bcnt >= hb && bcnt < hb + 64) begin
          int j;
          logic [7:0] b;
          j = bcnt - hb;
          b = fbyte(got_addr + 32'(j / 8));
          spi_miso = b[7 - (j % 8)];
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9: actual=unexpected response expected=none");
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " opcode"}, {56'h0, got_op}, {56'h0, q_op.pop_front()});
        check({t, " wire address"}, {32'h0, got_addr}, {32'h0, q_addr.pop_front()});
        check({t, " R7 data"}, rsp_data, q_data.pop_front());
        check("R8 latency", 64'(cyc - q_t0.pop_front()), 64'(q_lat.pop_front() + 1));
      end
    end
  end

  task automatic issue(input logic [WIN_AW-1:0] off, input logic a32,
                       input logic [7:0] page, input string tag);
    logic [31:0] fa, w;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    fa = BASE + {8'h00, off[WIN_AW-1:3], 3'b000};
    w  = a32 ? (fa ^ {page, 24'h0}) : {8'h00, fa[23:0]};
    q_op.push_back(a32 ? 8'h13 : 8'h03);
    q_addr.push_back(w);
    q_data.push_back(funit(w));
    q_t0.push_back(cyc);
    q_lat.push_back(a32 ? 208 : 192);
    q_tag.push_back(tag);
    req_offset = off; cfg_addr32 = a32; cfg_page = page; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_addr32 = ~a32;
    cfg_page = ~page;
    req_offset = ~off;
    check("R9 ready low while busy", {63'h0, req_ready}, 64'h0);
    check("R6 select low during read", {63'h0, spi_cs_n}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready", {63'h0, req_ready}, 64'h1);
    check("R1 cs_n", {63'h0, spi_cs_n}, 64'h1);
    check("R1 sck", {63'h0, spi_sck}, 64'h0);
    check("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
    rst_n = 1'b1;
    issue(24'h000000, 1'b0, 8'h00, "R4 offset0 short");
    issue(24'h000000, 1'b1, 8'h00, "R2 offset0 long");
    issue(24'hFFFFF8, 1'b1, 8'h00, "R2 last unit");
    issue(24'h123457, 1'b1, 8'h00, "R3 unaligned");
    issue(24'h000040, 1'b1, 8'h03, "R5 page 03");
    issue(24'h000105, 1'b0, 8'hFF, "R4 page ignored");
    issue(24'hABCDE8, 1'b1, 8'h80, "R5 page 80");
    issue(24'h7FFFFF, 1'b0, 8'h5C, "R10 short then flip");
    issue(24'h00A5A0, 1'b1, 8'h01, "R10 long then flip");
    while (q_data.size() != 0) @(negedge clk);
    @(negedge clk);
    check("R9 ready after response", {63'h0, req_ready}, 64'h1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule